// File: doc/BRIEF.md
# NAND Page ECC Syndrome Checker and Bit Fixer

This block checks a NAND page, one chunk at a time, against the error-correcting codes kept for it. Each chunk holds 512 data bytes and has a 3-byte code. For every chunk the block receives two codes: the one read back from the spare area and the one the parity generator computed over the data just read. The two codes are XORed and the bits are rearranged into a 24-bit difference vector. The number of set bits in that vector decides the result. A chunk is clean, carries one correctable bit error at a byte offset and bit index that the block reports, or is uncorrectable. An erased page, whose stored code reads as all ones while the computed code is all zeros, counts as clean.

A page is either a single chunk (small-page mode) or four chunks (large-page mode). A start pulse loads all codes. The block then checks one chunk per cycle and gives one result strobe per chunk. It stops early at the first uncorrectable chunk and ends with a page summary strobe. Each correction is kept in a small table. Data bytes streamed through the patch port come out one cycle later, with the recorded bit flipped when the byte's chunk and offset match a recorded correction.

Top module: `nand_ecc_fixer`

## Requirements
- R1: When a chunk's stored and computed codes are equal, its result has status 0 (clean) with offset 0 and bit 0. Status encoding: 0 clean, 1 corrected, 2 uncorrectable.
- R2: Each code is 24 bits: byte A in [7:0], byte B in [15:8], byte C in [23:16]. Let x be the XOR of the two codes. The difference vector d takes d[5:0] from C[7:2], d[13:6] from A, d[21:14] from B and d[23:22] from C[1:0]. When d has exactly 12 ones, the status is 1. The offset is {d23,d21,d19,d17,d15,d13,d11,d9,d7} with the MSB first, and the bit is {d5,d3,d1}.
- R3: When d has exactly one bit set, the status is 2.
- R4: A stored code of 24'hFFFFFF together with a computed code of 24'h000000 gives status 0.
- R5: Every other count of set bits (2 to 11, or 13 to 24, apart from the case in R4) gives status 2.
- R6: With large_mode low at start, only chunk 0 is checked and exactly one result is produced.
- R7: With large_mode high, chunks 0 to 3 are checked in order on consecutive cycles. res_chunk gives the index of each result.
- R8: Checking stops at the first chunk with status 2. page_done comes with that result, page_status is 2 and page_fail_chunk holds its index.
- R9: When no chunk is uncorrectable, page_done comes with the last result. page_status is 1 if any chunk was corrected and 0 otherwise. page_fail_chunk is then 0.
- R10: A start pulse while busy is high has no effect on the page being checked.
- R11: One cycle after pin_valid, pout_valid is high. pout_byte equals pin_byte with bit res_bit flipped when pin_chunk/pin_offset match a correction recorded in the current page. Otherwise pout_byte equals pin_byte unchanged.
- R12: An accepted start clears all recorded corrections.
- R13: After reset, busy, res_valid, page_done and pout_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load codes and begin a page check |
| large_mode | input | 1 | 1: four chunks, 0: one chunk |
| stored_codes | input | NCHUNK*24 | Codes read from flash, chunk k at [24k+23:24k] |
| calc_codes | input | NCHUNK*24 | Codes computed over read data, same layout |
| busy | output | 1 | Page check in progress |
| res_valid | output | 1 | One-cycle strobe per checked chunk |
| res_status | output | 2 | Chunk status (0/1/2) |
| res_chunk | output | CIDX_W | Chunk index of this result |
| res_offset | output | 9 | Byte offset of the bad bit |
| res_bit | output | 3 | Bit index of the bad bit |
| page_done | output | 1 | One-cycle strobe at the end of the page |
| page_status | output | 2 | Worst status of the page |
| page_fail_chunk | output | CIDX_W | First uncorrectable chunk |
| pin_valid | input | 1 | Patch input byte valid |
| pin_chunk | input | CIDX_W | Chunk of the patch byte |
| pin_offset | input | 9 | Offset of the patch byte |
| pin_byte | input | 8 | Data byte to patch |
| pout_valid | output | 1 | Patched byte valid |
| pout_byte | output | 8 | Patched data byte |

## Verification
The hardest case to reach is a correctable result, because it needs a difference vector with exactly one bit of each even/odd pair set, placed through the byte rearrangement. The bench builds it from the wanted offset and bit: it forms the pair pattern and maps it back into code bytes with the inverse of the R2 layout. It then XORs that mask into a stored code. The early stop is reached by placing a correctable chunk ahead of a single-bit-difference chunk. A start that should be ignored is sent in the cycle after the check begins, with different codes on the inputs.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int CODE_W     = 24;
  localparam int OFF_W      = 9;
  localparam int BIT_W      = 3;
  localparam int FIX_WEIGHT = CODE_W / 2;
  localparam int CNT_W      = $clog2(CODE_W + 1);

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_BAD   = 2'd2
  } ecc_stat_t;
endpackage

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
  import nand_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] computed,
  output ecc_stat_t         status,
  output logic [OFF_W-1:0]  offset,
  output logic [BIT_W-1:0]  bitidx
);
  localparam int NPAIR = CODE_W / 2;

  logic [CODE_W-1:0] x;
  logic [CODE_W-1:0] d;
  logic [CNT_W-1:0]  weight;
  logic              erased;
  logic [NPAIR-1:0]  addr;

  assign x      = stored ^ computed;
  // rearrange the code bytes into the syndrome order
  assign d      = {x[17:16], x[15:8], x[7:0], x[23:18]};
  assign weight = CNT_W'($countones(d));
  assign erased = (&stored) && (computed == '0);

  // odd bit of each pair carries one address bit
  genvar p;
  generate
    for (p = 0; p < NPAIR; p++) begin : g_pair
      assign addr[p] = d[2*p+1];
    end
  endgenerate

  always_comb begin
    status = ST_BAD;
    offset = '0;
    bitidx = '0;
    if (x == '0) begin
      status = ST_CLEAN;
    end else if (weight == CNT_W'(FIX_WEIGHT)) begin
      status = ST_FIXED;
      bitidx = addr[BIT_W-1:0];
      offset = addr[NPAIR-1:BIT_W];
    end else if (weight == CNT_W'(1)) begin
      status = ST_BAD;
    end else if (erased) begin
      status = ST_CLEAN;
    end
  end
endmodule

// File: rtl/nand_ecc_patch.sv
module nand_ecc_patch
  import nand_ecc_pkg::*;
#(
  parameter int NCHUNK = 4,
  parameter int CIDX_W = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fix_we,
  input  logic [CIDX_W-1:0] fix_chunk,
  input  logic [OFF_W-1:0]  fix_off,
  input  logic [BIT_W-1:0]  fix_bit,
  input  logic              pin_valid,
  input  logic [CIDX_W-1:0] pin_chunk,
  input  logic [OFF_W-1:0]  pin_offset,
  input  logic [7:0]        pin_byte,
  output logic              pout_valid,
  output logic [7:0]        pout_byte
);
  logic [NCHUNK-1:0] tab_v_q, tab_v_d;
  logic [OFF_W-1:0]  tab_off_q [NCHUNK];
  logic [BIT_W-1:0]  tab_bit_q [NCHUNK];
  logic              hit;
  logic [7:0]        flip;
  logic [7:0]        byte_d;

  always_comb begin
    tab_v_d = tab_v_q;
    if (clr) tab_v_d = '0;
    if (fix_we) tab_v_d[fix_chunk] = 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < NCHUNK; k++) begin : g_tab
      always_ff @(posedge clk) begin
        if (fix_we && (fix_chunk == CIDX_W'(k))) begin
          tab_off_q[k] <= fix_off;
          tab_bit_q[k] <= fix_bit;
        end
      end
    end
  endgenerate

  always_comb begin
    hit    = tab_v_q[pin_chunk] && (tab_off_q[pin_chunk] == pin_offset);
    flip   = hit ? (8'd1 << tab_bit_q[pin_chunk]) : 8'd0;
    byte_d = pin_byte ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab_v_q    <= '0;
      pout_valid <= 1'b0;
    end else begin
      tab_v_q    <= tab_v_d;
      pout_valid <= pin_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (pin_valid) pout_byte <= byte_d;
  end

  // R11
  patch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pout_valid |-> $past(pin_valid));

  // R11
  patch_unmatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_valid) && !$past(|tab_v_q) |-> pout_byte == $past(pin_byte));
endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int NCHUNK = 4,
  parameter int CIDX_W = 2
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     large_mode,
  input  logic [NCHUNK*CODE_W-1:0] stored_codes,
  input  logic [NCHUNK*CODE_W-1:0] calc_codes,
  output logic                     busy,
  output logic                     res_valid,
  output ecc_stat_t                res_status,
  output logic [CIDX_W-1:0]        res_chunk,
  output logic [OFF_W-1:0]         res_offset,
  output logic [BIT_W-1:0]         res_bit,
  output logic                     page_done,
  output ecc_stat_t                page_status,
  output logic [CIDX_W-1:0]        page_fail_chunk,
  output logic                     clr,
  output logic                     fix_we,
  output logic [CIDX_W-1:0]        fix_chunk,
  output logic [OFF_W-1:0]         fix_off,
  output logic [BIT_W-1:0]         fix_bit
);
  typedef enum logic {S_IDLE, S_RUN} seq_st_t;

  seq_st_t           st_q, st_d;
  logic [CIDX_W-1:0] idx_q, idx_d;
  logic              large_q, large_d;
  logic              any_fix_q, any_fix_d;
  logic              load_en;
  logic [CODE_W-1:0] stored_q [NCHUNK];
  logic [CODE_W-1:0] calc_q   [NCHUNK];
  logic [CIDX_W-1:0] last_idx;
  logic              last;

  ecc_stat_t         cls_status;
  logic [OFF_W-1:0]  cls_off;
  logic [BIT_W-1:0]  cls_bit;

  logic              rv_d, done_d;
  ecc_stat_t         rs_d, ps_d;
  logic [CIDX_W-1:0] rc_d, pf_d;
  logic [OFF_W-1:0]  ro_d;
  logic [BIT_W-1:0]  rb_d;

  genvar k;
  generate
    for (k = 0; k < NCHUNK; k++) begin : g_load
      always_ff @(posedge clk) begin
        if (load_en) begin
          stored_q[k] <= stored_codes[k*CODE_W +: CODE_W];
          calc_q[k]   <= calc_codes[k*CODE_W +: CODE_W];
        end
      end
    end
  endgenerate

  nand_ecc_classify u_cls (
    .stored   (stored_q[idx_q]),
    .computed (calc_q[idx_q]),
    .status   (cls_status),
    .offset   (cls_off),
    .bitidx   (cls_bit)
  );

  assign last_idx  = large_q ? CIDX_W'(NCHUNK - 1) : '0;
  assign last      = (cls_status == ST_BAD) || (idx_q == last_idx);
  assign fix_chunk = idx_q;
  assign fix_off   = cls_off;
  assign fix_bit   = cls_bit;
  assign busy      = (st_q == S_RUN);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    large_d   = large_q;
    any_fix_d = any_fix_q;
    load_en   = 1'b0;
    clr       = 1'b0;
    fix_we    = 1'b0;
    rv_d      = 1'b0;
    rs_d      = res_status;
    rc_d      = res_chunk;
    ro_d      = res_offset;
    rb_d      = res_bit;
    done_d    = 1'b0;
    ps_d      = page_status;
    pf_d      = page_fail_chunk;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d      = S_RUN;
          idx_d     = '0;
          large_d   = large_mode;
          any_fix_d = 1'b0;
          load_en   = 1'b1;
          clr       = 1'b1;
        end
      end
      default: begin
        rv_d   = 1'b1;
        rs_d   = cls_status;
        rc_d   = idx_q;
        ro_d   = cls_off;
        rb_d   = cls_bit;
        fix_we = (cls_status == ST_FIXED);
        if (cls_status == ST_FIXED) any_fix_d = 1'b1;
        if (last) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
          if (cls_status == ST_BAD) begin
            ps_d = ST_BAD;
            pf_d = idx_q;
          end else begin
            ps_d = (any_fix_q || cls_status == ST_FIXED) ? ST_FIXED : ST_CLEAN;
            pf_d = '0;
          end
        end else begin
          idx_d = idx_q + CIDX_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q            <= S_IDLE;
      idx_q           <= '0;
      large_q         <= 1'b0;
      any_fix_q       <= 1'b0;
      res_valid       <= 1'b0;
      res_status      <= ST_CLEAN;
      res_chunk       <= '0;
      res_offset      <= '0;
      res_bit         <= '0;
      page_done       <= 1'b0;
      page_status     <= ST_CLEAN;
      page_fail_chunk <= '0;
    end else begin
      st_q            <= st_d;
      idx_q           <= idx_d;
      large_q         <= large_d;
      any_fix_q       <= any_fix_d;
      res_valid       <= rv_d;
      res_status      <= rs_d;
      res_chunk       <= rc_d;
      res_offset      <= ro_d;
      res_bit         <= rb_d;
      page_done       <= done_d;
      page_status     <= ps_d;
      page_fail_chunk <= pf_d;
    end
  end

  // R8
  bad_ends_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_status == ST_BAD |-> page_done && page_fail_chunk == res_chunk);

  // R7
  chunk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !page_done |=> res_valid && res_chunk == $past(res_chunk) + CIDX_W'(1));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(res_valid) |-> res_chunk != '0);

  // R6
  small_one_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_done && !large_q |-> res_valid && res_chunk == '0);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> !busy && res_valid);
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import nand_ecc_pkg::*;
#(
  parameter int NCHUNK = 4,
  localparam int CIDX_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     large_mode,
  input  logic [NCHUNK*CODE_W-1:0] stored_codes,
  input  logic [NCHUNK*CODE_W-1:0] calc_codes,
  output logic                     busy,
  output logic                     res_valid,
  output logic [1:0]               res_status,
  output logic [CIDX_W-1:0]        res_chunk,
  output logic [OFF_W-1:0]         res_offset,
  output logic [BIT_W-1:0]         res_bit,
  output logic                     page_done,
  output logic [1:0]               page_status,
  output logic [CIDX_W-1:0]        page_fail_chunk,
  input  logic                     pin_valid,
  input  logic [CIDX_W-1:0]        pin_chunk,
  input  logic [OFF_W-1:0]         pin_offset,
  input  logic [7:0]               pin_byte,
  output logic                     pout_valid,
  output logic [7:0]               pout_byte
);
  ecc_stat_t         rs, ps;
  logic              clr, fix_we;
  logic [CIDX_W-1:0] fix_chunk;
  logic [OFF_W-1:0]  fix_off;
  logic [BIT_W-1:0]  fix_bit;

  nand_ecc_seq #(.NCHUNK(NCHUNK), .CIDX_W(CIDX_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .large_mode      (large_mode),
    .stored_codes    (stored_codes),
    .calc_codes      (calc_codes),
    .busy            (busy),
    .res_valid       (res_valid),
    .res_status      (rs),
    .res_chunk       (res_chunk),
    .res_offset      (res_offset),
    .res_bit         (res_bit),
    .page_done       (page_done),
    .page_status     (ps),
    .page_fail_chunk (page_fail_chunk),
    .clr             (clr),
    .fix_we          (fix_we),
    .fix_chunk       (fix_chunk),
    .fix_off         (fix_off),
    .fix_bit         (fix_bit)
  );

  nand_ecc_patch #(.NCHUNK(NCHUNK), .CIDX_W(CIDX_W)) u_patch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .fix_we     (fix_we),
    .fix_chunk  (fix_chunk),
    .fix_off    (fix_off),
    .fix_bit    (fix_bit),
    .pin_valid  (pin_valid),
    .pin_chunk  (pin_chunk),
    .pin_offset (pin_offset),
    .pin_byte   (pin_byte),
    .pout_valid (pout_valid),
    .pout_byte  (pout_byte)
  );

  assign res_status  = rs;
  assign page_status = ps;

  // R1
  clean_has_no_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_status == 2'd0 |-> res_offset == '0 && res_bit == '0);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !res_valid);
endmodule

// File: tb/nand_ecc_fixer_bench.sv
module nand_ecc_fixer_bench;
  localparam int NCH = 4;
  localparam int CW  = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          large_mode = 1'b0;
  logic [NCH*CW-1:0] stored_codes = '0;
  logic [NCH*CW-1:0] calc_codes = '0;
  logic          busy, res_valid, page_done, pout_valid;
  logic [1:0]    res_status, page_status, res_chunk, page_fail_chunk;
  logic [8:0]    res_offset;
  logic [2:0]    res_bit;
  logic          pin_valid = 1'b0;
  logic [1:0]    pin_chunk = '0;
  logic [8:0]    pin_offset = '0;
  logic [7:0]    pin_byte = '0;
  logic [7:0]    pout_byte;

  int total = 0;
  int bad = 0;

  int g_n;
  int g_st  [NCH];
  int g_ch  [NCH];
  int g_off [NCH];
  int g_bit [NCH];
  int g_pstat, g_pfail, g_done;

  always #10 clk = ~clk;

  nand_ecc_fixer u_nand_ecc_fixer (
    .clk(clk), .rst_n(rst_n), .start(start), .large_mode(large_mode),
    .stored_codes(stored_codes), .calc_codes(calc_codes), .busy(busy),
    .res_valid(res_valid), .res_status(res_status), .res_chunk(res_chunk),
    .res_offset(res_offset), .res_bit(res_bit), .page_done(page_done),
    .page_status(page_status), .page_fail_chunk(page_fail_chunk),
    .pin_valid(pin_valid), .pin_chunk(pin_chunk), .pin_offset(pin_offset),
    .pin_byte(pin_byte), .pout_valid(pout_valid), .pout_byte(pout_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pair pattern for a single data-bit error, then mapped into code bytes
  function automatic logic [23:0] fix_mask(input int off, input int bt);
    logic [11:0] a;
    logic [23:0] d, m;
    a = {off[8:0], bt[2:0]};
    for (int p = 0; p < 12; p++) begin
      d[2*p+1] = a[p];
      d[2*p]   = ~a[p];
    end
    m[23:18] = d[5:0];
    m[7:0]   = d[13:6];
    m[15:8]  = d[21:14];
    m[17:16] = d[23:22];
    return m;
  endfunction

  task automatic set_chunk(input int k, input logic [23:0] s, input logic [23:0] c);
    stored_codes[k*CW +: CW] = s;
    calc_codes[k*CW +: CW]   = c;
  endtask

  task automatic run_page(input logic lg, input bit poke);
    g_n = 0; g_done = 0; g_pstat = -1; g_pfail = -1;
    @(negedge clk);
    large_mode = lg;
    start = 1'b1;
    for (int cyc = 0; cyc < 20 && g_done == 0; cyc++) begin
      @(negedge clk);
      if (poke && cyc == 0) begin
        start = 1'b1;
        large_mode = 1'b0;
        stored_codes = ~stored_codes;
      end else begin
        start = 1'b0;
      end
      if (res_valid && g_n < NCH) begin
        g_st[g_n]  = res_status;
        g_ch[g_n]  = res_chunk;
        g_off[g_n] = res_offset;
        g_bit[g_n] = res_bit;
        g_n++;
      end
      if (page_done) begin
        g_done  = 1;
        g_pstat = page_status;
        g_pfail = page_fail_chunk;
      end
    end
    start = 1'b0;
    chk("page_done seen", g_done, 1);
  endtask

  task automatic patch(input int ch, input int off, input int b, input int exp, input string req);
    @(negedge clk);
    pin_valid = 1'b1; pin_chunk = ch[1:0]; pin_offset = off[8:0]; pin_byte = b[7:0];
    @(negedge clk);
    pin_valid = 1'b0;
    chk({req, " pout_valid"}, pout_valid, 1);
    chk({req, " pout_byte"}, pout_byte, exp);
  endtask

  task automatic t_reset();
    chk("R13 busy", busy, 0);
    chk("R13 res_valid", res_valid, 0);
    chk("R13 page_done", page_done, 0);
    chk("R13 pout_valid", pout_valid, 0);
  endtask

  task automatic t_clean();
    set_chunk(0, 24'hA5C33C, 24'hA5C33C);
    run_page(1'b0, 1'b0);
    chk("R1 count", g_n, 1);
    chk("R1 status", g_st[0], 0);
    chk("R1 offset", g_off[0], 0);
    chk("R1 bit", g_bit[0], 0);
    chk("R9 page status clean", g_pstat, 0);
  endtask

  task automatic t_fix_small(input int off, input int bt);
    set_chunk(0, 24'h5A0FF0, 24'h5A0FF0 ^ fix_mask(off, bt));
    run_page(1'b0, 1'b0);
    chk("R2 status", g_st[0], 1);
    chk("R2 offset", g_off[0], off);
    chk("R2 bit", g_bit[0], bt);
    chk("R9 page status fixed", g_pstat, 1);
  endtask

  task automatic t_single();
    set_chunk(0, 24'h123456, 24'h123456 ^ 24'h000400);
    run_page(1'b0, 1'b0);
    chk("R3 status", g_st[0], 2);
    chk("R8 page status", g_pstat, 2);
    chk("R8 fail chunk", g_pfail, 0);
  endtask

  task automatic t_erased();
    set_chunk(0, 24'hFFFFFF, 24'h000000);
    run_page(1'b0, 1'b0);
    chk("R4 erased clean", g_st[0], 0);
    set_chunk(0, 24'hFFFFFF, 24'h000001);
    run_page(1'b0, 1'b0);
    chk("R5 near-erased bad", g_st[0], 2);
  endtask

  task automatic t_other();
    set_chunk(0, 24'h00FF00, 24'h00FF00 ^ 24'h000003);
    run_page(1'b0, 1'b0);
    chk("R5 weight2", g_st[0], 2);
    set_chunk(0, 24'h123456, 24'h123456 ^ 24'hFFFFFF);
    run_page(1'b0, 1'b0);
    chk("R5 weight24", g_st[0], 2);
    set_chunk(0, 24'h000000, 24'h001FFF);
    run_page(1'b0, 1'b0);
    chk("R5 weight13", g_st[0], 2);
  endtask

  task automatic t_small_ignores_rest();
    set_chunk(0, 24'h111111, 24'h111111);
    set_chunk(1, 24'h222222, 24'h222223);
    run_page(1'b0, 1'b0);
    chk("R6 count", g_n, 1);
    chk("R6 chunk", g_ch[0], 0);
    chk("R6 page status", g_pstat, 0);
  endtask

  task automatic t_large_mix();
    set_chunk(0, 24'h0F0F0F, 24'h0F0F0F);
    set_chunk(1, 24'h333333, 24'h333333 ^ fix_mask(9'h1A5, 6));
    set_chunk(2, 24'hFFFFFF, 24'h000000);
    set_chunk(3, 24'hC0FFEE, 24'hC0FFEE ^ fix_mask(511, 0));
    run_page(1'b1, 1'b0);
    chk("R7 count", g_n, 4);
    for (int k = 0; k < 4; k++) chk("R7 chunk order", g_ch[k], k);
    chk("R7 st0", g_st[0], 0);
    chk("R7 st1", g_st[1], 1);
    chk("R7 off1", g_off[1], 9'h1A5);
    chk("R7 st2", g_st[2], 0);
    chk("R7 off3", g_off[3], 511);
    chk("R9 page status", g_pstat, 1);
    chk("R9 fail chunk", g_pfail, 0);
    patch(1, 9'h1A5, 8'h0F, 8'h4F, "R11 flip chunk1");
    patch(3, 511, 8'hFF, 8'hFE, "R11 flip chunk3");
    patch(2, 9'h1A5, 8'h0F, 8'h0F, "R11 other chunk");
    patch(1, 9'h1A4, 8'h81, 8'h81, "R11 other offset");
  endtask

  task automatic t_large_stop();
    set_chunk(0, 24'h000000, fix_mask(0, 7));
    set_chunk(1, 24'h777777, 24'h777777 ^ 24'h020000);
    set_chunk(2, 24'h555555, 24'h555555);
    set_chunk(3, 24'h555555, 24'h555555);
    run_page(1'b1, 1'b0);
    chk("R8 count", g_n, 2);
    chk("R8 st0", g_st[0], 1);
    chk("R8 st1", g_st[1], 2);
    chk("R8 page status", g_pstat, 2);
    chk("R8 fail chunk", g_pfail, 1);
    patch(0, 0, 8'h00, 8'h80, "R11 flip before stop");
  endtask

  task automatic t_busy_start();
    for (int k = 0; k < 4; k++) set_chunk(k, 24'h010203 * (k + 1), 24'h010203 * (k + 1));
    run_page(1'b1, 1'b1);
    chk("R10 count", g_n, 4);
    chk("R10 last chunk", g_ch[3], 3);
    chk("R10 status", g_st[1], 0);
    chk("R10 page status", g_pstat, 0);
  endtask

  task automatic t_clear();
    set_chunk(0, 24'h000000, fix_mask(5, 2));
    run_page(1'b0, 1'b0);
    patch(0, 5, 8'h00, 8'h04, "R11 recorded");
    set_chunk(0, 24'hABCDEF, 24'hABCDEF);
    run_page(1'b0, 1'b0);
    patch(0, 5, 8'h00, 8'h00, "R12 cleared");
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_fix_small(0, 0);
    t_fix_small(9'h155, 5);
    t_fix_small(9'h0AA, 3);
    t_fix_small(511, 7);
    t_single();
    t_erased();
    t_other();
    t_small_ignores_rest();
    t_large_mix();
    t_large_stop();
    t_busy_start();
    t_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule